// File: doc/BRIEF.md
# Grouped Interrupt Status Controller

This block gathers eight event sources from a 2D graphics engine into two interrupt groups. Four sources belong to the blitter group: destination buffer full, source-A buffer full, source-B buffer full and blit done. The other four belong to the display output group: output buffer full, vertical sync, output underflow and last line captured. Each event is a one-cycle pulse. It latches a sticky status bit that stays set until software clears it.

Software reads the latched bits from a read-only status word. It clears bits by writing ones to a separate clear word. It enables each source toward its group line through a mask word. A control word holds a display-enable bit. The vertical-sync source can only latch while that bit is set. Each group drives one registered interrupt line, so the blitter side and the display side can be routed to different interrupt inputs.

The register port is a plain synchronous slave. Reads are combinational: while the read strobe is high, the read data shows the addressed word, and otherwise it is zero. Writes take effect at the clock edge that samples the write strobe.

Top module: `gfxIntGroupCtl`

## Requirements
- R1: A synchronous active-low reset clears the following: all eight status bits, the mask word, the display-enable bit and both group interrupt lines.
- R2: A pulse on blitter event input k (k = 0..3) sets status bit k at the sampling clock edge. The bit order is destination full, source-A full, source-B full, blit done. The bit is readable at word offset 0x0 right after that edge.
- R3: A pulse on output event input k (k = 0..3) sets status bit 4+k. The bit order is output buffer full, vertical sync, underflow, last line captured.
- R4: A set status bit stays set across idle cycles. It also stays set across clear writes whose data bit at its position is 0.
- R5: Writing data with bit n = 1 to offset 0x4 clears status bit n at that write's clock edge.
- R6: The vertical-sync event (output input 1, status bit 5) sets its bit only while display-enable (bit 0 of offset 0xC) is 1. While display-enable is 0, the pulse leaves status unchanged.
- R7: Offset 0x4 always reads as zero. A write to offset 0x0 leaves the status bits unchanged.
- R8: When an event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R9: The mask word at offset 0x8 uses the status bit layout and reads back as written. Each group line is registered: it equals the OR of (status AND mask) over the group's bits as they stood in the previous cycle.
- R10: The blitter line depends only on bits 3:0 of status and mask, and the output line depends only on bits 7:4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe |
| regAddr | input | 4 | Byte address, word offsets 0x0/0x4/0x8/0xC |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, zero when not reading |
| blitEvt | input | 4 | Blitter group event pulses |
| outEvt | input | 4 | Output group event pulses |
| blitIrq | output | 1 | Blitter group interrupt line |
| outIrq | output | 1 | Output group interrupt line |

## Verification
A status bit that is lost, stuck or mapped wrongly shows up in the status word on the first read after the edge that should have changed it. It also reaches the group line one cycle later, once the matching mask bit is set. Errors in the collision rule, the sync gating and the clear decoding show up in a single status read right after the stimulus. A sweep over all 256 event patterns, each with a varied mask, exposes any cross-coupling between the groups or between the mask and the line logic within two cycles of the mask write.

// File: rtl/gfxIntPkg.sv
package gfxIntPkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CLEAR  = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_DISP   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    clearWr;
    logic    maskWr;
    logic    dispWr;
    logic    readEn;
    regSel_e readSel;
  } regStrobe_t;

endpackage

// File: rtl/gfxIntCtrl.sv
module gfxIntCtrl
  import gfxIntPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);

  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] WORD_STATUS = WORD_W'(0);
  localparam logic [WORD_W-1:0] WORD_CLEAR  = WORD_W'(1);
  localparam logic [WORD_W-1:0] WORD_MASK   = WORD_W'(2);
  localparam logic [WORD_W-1:0] WORD_DISP   = WORD_W'(3);

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedByteLane;
  logic              hitStatus, hitClear, hitMask, hitDisp;

  assign wordIdx        = regAddr[ADDR_W-1:2];
  assign unusedByteLane = regAddr[1:0];

  assign hitStatus = (wordIdx == WORD_STATUS);
  assign hitClear  = (wordIdx == WORD_CLEAR);
  assign hitMask   = (wordIdx == WORD_MASK);
  assign hitDisp   = (wordIdx == WORD_DISP);

  always_comb begin
    strb.clearWr = regWrite && hitClear;
    strb.maskWr  = regWrite && hitMask;
    strb.dispWr  = regWrite && hitDisp;
    strb.readEn  = regRead && (hitStatus || hitClear || hitMask || hitDisp);
    if (hitMask)       strb.readSel = SEL_MASK;
    else if (hitDisp)  strb.readSel = SEL_DISP;
    else if (hitClear) strb.readSel = SEL_CLEAR;
    else               strb.readSel = SEL_STATUS;
  end

endmodule

// File: rtl/gfxIntDatapath.sv
module gfxIntDatapath
  import gfxIntPkg::*;
#(
  parameter int SRC_PER_GRP = 4,
  parameter int DATA_W      = 32,
  parameter int VSYNC_IDX   = 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  regStrobe_t               strb,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [SRC_PER_GRP-1:0]   blitEvt,
  input  logic [SRC_PER_GRP-1:0]   outEvt,
  output logic [DATA_W-1:0]        rdata,
  output logic [2*SRC_PER_GRP-1:0] statusVec,
  output logic [2*SRC_PER_GRP-1:0] maskVec,
  output logic                     dispEn,
  output logic                     blitIrq,
  output logic                     outIrq
);

  localparam int NSRC = 2 * SRC_PER_GRP;

  logic [SRC_PER_GRP-1:0] outQual;
  logic [NSRC-1:0]        setVec;
  logic [NSRC-1:0]        clrVec;
  logic [DATA_W-1:0]      unusedWdata;

  assign unusedWdata = wdata;

  for (genvar i = 0; i < SRC_PER_GRP; i++) begin : g_outQual
    if (i == VSYNC_IDX) begin : g_vsync
      assign outQual[i] = outEvt[i] & dispEn;
    end else begin : g_plain
      assign outQual[i] = outEvt[i];
    end
  end

  assign setVec = {outQual, blitEvt};
  assign clrVec = strb.clearWr ? wdata[NSRC-1:0] : '0;

  for (genvar n = 0; n < NSRC; n++) begin : g_status
    always_ff @(posedge clk) begin
      if (!rstN)          statusVec[n] <= 1'b0;
      else if (setVec[n]) statusVec[n] <= 1'b1;
      else if (clrVec[n]) statusVec[n] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskVec <= '0;
      dispEn  <= 1'b0;
    end else begin
      if (strb.maskWr) maskVec <= wdata[NSRC-1:0];
      if (strb.dispWr) dispEn  <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blitIrq <= 1'b0;
      outIrq  <= 1'b0;
    end else begin
      blitIrq <= |(statusVec[SRC_PER_GRP-1:0] & maskVec[SRC_PER_GRP-1:0]);
      outIrq  <= |(statusVec[NSRC-1:SRC_PER_GRP] & maskVec[NSRC-1:SRC_PER_GRP]);
    end
  end

  always_comb begin
    rdata = '0;
    if (strb.readEn) begin
      unique case (strb.readSel)
        SEL_STATUS: rdata[NSRC-1:0] = statusVec;
        SEL_MASK:   rdata[NSRC-1:0] = maskVec;
        SEL_DISP:   rdata[0]        = dispEn;
        SEL_CLEAR:  rdata           = '0;
        default:    rdata           = '0;
      endcase
    end
  end

endmodule

// File: rtl/gfxIntGroupCtl.sv
module gfxIntGroupCtl
  import gfxIntPkg::*;
#(
  parameter int SRC_PER_GRP = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int VSYNC_IDX   = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrite,
  input  logic                   regRead,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [SRC_PER_GRP-1:0] blitEvt,
  input  logic [SRC_PER_GRP-1:0] outEvt,
  output logic                   blitIrq,
  output logic                   outIrq
);

  localparam int NSRC = 2 * SRC_PER_GRP;

  regStrobe_t      strb;
  logic [NSRC-1:0] statusVec;
  logic [NSRC-1:0] maskVec;
  logic            dispEn;

  gfxIntCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrite (regWrite),
    .regRead  (regRead),
    .regAddr  (regAddr),
    .strb     (strb)
  );

  gfxIntDatapath #(
    .SRC_PER_GRP (SRC_PER_GRP),
    .DATA_W      (DATA_W),
    .VSYNC_IDX   (VSYNC_IDX)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wdata     (regWdata),
    .blitEvt   (blitEvt),
    .outEvt    (outEvt),
    .rdata     (regRdata),
    .statusVec (statusVec),
    .maskVec   (maskVec),
    .dispEn    (dispEn),
    .blitIrq   (blitIrq),
    .outIrq    (outIrq)
  );

endmodule

// File: rtl/gfxIntChecker.sv
module gfxIntChecker #(
  parameter int SRC_PER_GRP = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int VSYNC_IDX   = 1
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWrite,
  input logic                     regRead,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [DATA_W-1:0]        regWdata,
  input logic [DATA_W-1:0]        regRdata,
  input logic [SRC_PER_GRP-1:0]   blitEvt,
  input logic [SRC_PER_GRP-1:0]   outEvt,
  input logic [2*SRC_PER_GRP-1:0] statusVec,
  input logic [2*SRC_PER_GRP-1:0] maskVec,
  input logic                     dispEn,
  input logic                     blitIrq,
  input logic                     outIrq
);

  localparam int NSRC = 2 * SRC_PER_GRP;
  localparam int VBIT = SRC_PER_GRP + VSYNC_IDX;
  localparam logic [ADDR_W-3:0] CLR_WORD = (ADDR_W-2)'(1);

  logic [NSRC-1:0] chkClr;
  logic [NSRC-1:0] chkSet;
  logic [NSRC-1:0] vbitOnly;

  always_comb begin
    chkClr = (regWrite && regAddr[ADDR_W-1:2] == CLR_WORD) ? regWdata[NSRC-1:0] : '0;
    chkSet = {outEvt, blitEvt};
    if (!dispEn) chkSet[VBIT] = 1'b0;
    vbitOnly = '0;
    vbitOnly[VBIT] = 1'b1;
  end

  // R2 R3 R8: a qualified event always leaves its bit set next cycle
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(chkSet)) & ~statusVec) == '0));

  // R4: set bits not named in a clear write stay set
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusVec) & ~$past(chkClr)) & ~statusVec) == '0));

  // R5: cleared bits without a coincident event drop
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(chkClr) & ~$past(chkSet)) & statusVec) == '0));

  // R6: gated vertical sync does not latch
  assert_vsync_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outEvt[VSYNC_IDX] && !dispEn && ((statusVec & vbitOnly) == '0)) |=> ((statusVec & vbitOnly) == '0));

  // R7: clear word reads as zero
  assert_clear_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRead && regAddr[ADDR_W-1:2] == CLR_WORD) |-> (regRdata == '0));

  // R9 R10: registered group lines
  assert_blit_line_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (blitIrq == $past(|(statusVec[SRC_PER_GRP-1:0] & maskVec[SRC_PER_GRP-1:0]))));

  assert_out_line_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (outIrq == $past(|(statusVec[NSRC-1:SRC_PER_GRP] & maskVec[NSRC-1:SRC_PER_GRP]))));

endmodule

bind gfxIntGroupCtl gfxIntChecker #(
  .SRC_PER_GRP (SRC_PER_GRP),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .VSYNC_IDX   (VSYNC_IDX)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrite  (regWrite),
  .regRead   (regRead),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .regRdata  (regRdata),
  .blitEvt   (blitEvt),
  .outEvt    (outEvt),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .dispEn    (dispEn),
  .blitIrq   (blitIrq),
  .outIrq    (outIrq)
);

// File: tb/tb_gfxIntGroupCtl.sv
`timescale 1ns/100ps
module tb_gfxIntGroupCtl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic        regRead = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] regWdata = 32'h0;
  logic [3:0]  blitEvt = 4'h0;
  logic [3:0]  outEvt = 4'h0;
  logic [31:0] regRdata;
  logic        blitIrq, outIrq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mStatus = 8'h0;
  logic [7:0] mMask = 8'h0;
  logic       mDisp = 1'b0;
  logic       mBIrq = 1'b0;
  logic       mOIrq = 1'b0;

  gfxIntGroupCtl dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .blitEvt(blitEvt), .outEvt(outEvt), .blitIrq(blitIrq), .outIrq(outIrq)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock with the given inputs; model follows the requirements
  task automatic cycle(input logic [3:0] be, input logic [3:0] oe,
                       input logic wr, input logic [3:0] a, input logic [31:0] d);
    logic [3:0] oq;
    logic [7:0] setV, clrV;
    blitEvt = be; outEvt = oe; regWrite = wr; regAddr = a; regWdata = d;
    @(posedge clk);
    oq = oe;
    if (!mDisp) oq[1] = 1'b0;
    setV = {oq, be};
    clrV = (wr && a == 4'h4) ? d[7:0] : 8'h0;
    mBIrq = |(mStatus[3:0] & mMask[3:0]);
    mOIrq = |(mStatus[7:4] & mMask[7:4]);
    mStatus = (mStatus & ~clrV) | setV;
    if (wr && a == 4'h8) mMask = d[7:0];
    if (wr && a == 4'hC) mDisp = d[0];
    #1;
    blitEvt = 4'h0; outEvt = 4'h0; regWrite = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(4'h0, 4'h0, 1'b0, 4'h0, 32'h0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regRead = 1'b1; regAddr = a;
    #0.5;
    d = regRdata;
    regRead = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cycle(4'h0, 4'h0, 1'b1, a, d);
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] v;
    rd(4'h0, v); chk({tag, " status"}, v, {24'h0, mStatus});
    rd(4'h8, v); chk({tag, " mask"}, v, {24'h0, mMask});
    rd(4'hC, v); chk({tag, " disp"}, v, {31'h0, mDisp});
    chk({tag, " blitIrq"}, {31'h0, blitIrq}, {31'h0, mBIrq});
    chk({tag, " outIrq"}, {31'h0, outIrq}, {31'h0, mOIrq});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    mStatus = 8'h0; mMask = 8'h0; mDisp = 1'b0; mBIrq = 1'b0; mOIrq = 1'b0;
    rstN = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  bitN, m;
    doReset();
    checkAll("R1 reset");

    // per-source directed pass
    wr(4'hC, 32'h1);
    for (int i = 0; i < 8; i++) begin
      bitN = 8'(1 << i);
      wr(4'h8, 32'h0);
      cycle(bitN[3:0], bitN[7:4], 1'b0, 4'h0, 32'h0);
      rd(4'h0, v);
      chk(i < 4 ? "R2 set" : "R3 set", v, {24'h0, bitN});
      wr(4'h4, {24'h0, ~bitN});
      rd(4'h0, v); chk("R4 zero-clear", v, {24'h0, bitN});
      idle(3);
      rd(4'h0, v); chk("R4 idle", v, {24'h0, bitN});
      wr(4'h8, {24'h0, bitN});
      chk("R9 line latency", {30'h0, blitIrq, outIrq}, 32'h0);
      idle(1);
      chk("R9 line", {31'h0, (i < 4) ? blitIrq : outIrq}, 32'h1);
      chk("R10 other line", {31'h0, (i < 4) ? outIrq : blitIrq}, 32'h0);
      wr(4'h4, {24'h0, bitN});
      rd(4'h0, v); chk("R5 clear", v, 32'h0);
      idle(1);
      chk("R9 line drop", {30'h0, blitIrq, outIrq}, 32'h0);
    end

    // registered line: mask first, event after
    wr(4'h8, 32'hFF);
    cycle(4'h8, 4'h0, 1'b0, 4'h0, 32'h0);
    rd(4'h0, v); chk("R2 done bit", v, 32'h08);
    chk("R9 not yet", {31'h0, blitIrq}, 32'h0);
    idle(1);
    chk("R9 one later", {31'h0, blitIrq}, 32'h1);
    wr(4'h4, 32'hFF);
    idle(1);

    // vertical sync gating
    wr(4'hC, 32'h0);
    cycle(4'h0, 4'h2, 1'b0, 4'h0, 32'h0);
    rd(4'h0, v); chk("R6 gated", v, 32'h0);
    chk("R6 gated line", {31'h0, outIrq}, 32'h0);
    idle(1);
    chk("R6 gated line later", {31'h0, outIrq}, 32'h0);
    wr(4'hC, 32'h1);
    rd(4'hC, v); chk("R6 disp readback", v, 32'h1);
    cycle(4'h0, 4'h2, 1'b0, 4'h0, 32'h0);
    rd(4'h0, v); chk("R6 enabled", v, 32'h20);

    // status write ignored, clear reads zero
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R7 status write 0", v, 32'h20);
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R7 status write 1s", v, 32'h20);
    rd(4'h4, v); chk("R7 clear reads zero", v, 32'h0);

    // collisions
    wr(4'h4, 32'hFF);
    cycle(4'h4, 4'h0, 1'b0, 4'h0, 32'h0);
    cycle(4'h4, 4'h0, 1'b1, 4'h4, 32'h04);
    rd(4'h0, v); chk("R8 set wins held", v, 32'h04);
    cycle(4'h0, 4'h1, 1'b1, 4'h4, 32'hFF);
    rd(4'h0, v); chk("R8 set wins fresh", v, 32'h10);
    checkAll("R8 model");

    // exhaustive event pattern sweep
    for (int p = 0; p < 256; p++) begin
      m = 8'((p * 37 + 11) & 255);
      wr(4'h4, 32'hFF);
      cycle(p[3:0], p[7:4], 1'b0, 4'h0, 32'h0);
      wr(4'h8, {24'h0, m});
      idle(2);
      rd(4'h0, v); chk("R3 sweep status", v, 32'(p));
      chk("R10 sweep blit", {31'h0, blitIrq}, {31'h0, |(p[3:0] & m[3:0])});
      chk("R10 sweep out", {31'h0, outIrq}, {31'h0, |(p[7:4] & m[7:4])});
      if ((p % 32) == 0) checkAll("R9 sweep");
    end

    // reset with state loaded
    wr(4'h8, 32'hFF);
    cycle(4'hF, 4'hF, 1'b0, 4'h0, 32'h0);
    idle(2);
    doReset();
    checkAll("R1 mid reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule